// File: doc/BRIEF.md
# Received Pause Transmit Gate

This block sits beside a gigabit Ethernet MAC and decides when the transmitter may start a new frame. The receive path decodes each pause frame it has validated and offers four fields with a one-cycle strobe: the destination address, the EtherType, the opcode and the 16-bit quanta value. The block checks these fields. A valid XOFF asks for a hold of quanta × 512 bit times. On an 8-bit-per-clock interface that is quanta × 64 clocks. An XON is a valid pause frame with a zero quanta value, and it lifts the hold at once.

A frame that is already leaving the transmitter is never cut short. If an XOFF arrives while `tx_busy` is high and `tx_eof` is low, the block parks the requested quanta in the DEFER state. The hold starts in the cycle after the frame ends. A configuration bit makes the block ignore every received pause frame. The remaining quanta count is an output, so a user can watch how much pause time is left.

A three-state machine runs the block. IDLE means no pause. DEFER means a pause is waiting for the current frame to end. HOLD means the transmitter is held and the slot timer runs. The transitions are:
- IDLE→HOLD: accepted XOFF while no frame is in progress.
- IDLE→DEFER: accepted XOFF during a frame.
- DEFER→HOLD: the frame ends.
- DEFER→IDLE: accepted XON.
- HOLD→HOLD (reload): accepted XOFF.
- HOLD→IDLE: accepted XON, or the timer expires.

Synchronous reset forces IDLE from any state.

Top module: `pause_tx_gate`

## Requirements
- R1: After an accepted XOFF with quanta Q > 0 and no frame in progress, `tx_hold` is high for exactly Q × 64 consecutive cycles. Those cycles start in the cycle after the strobe is sampled.
- R2: If an XOFF is accepted while a frame is in progress (`tx_busy`=1 and `tx_eof`=0), `tx_hold` stays low. The full Q × 64 hold begins in the cycle after the frame ends, which means `tx_eof`=1 or `tx_busy`=0 is sampled.
- R3: During a hold, `pause_remaining` is never zero. It drops by exactly one every 64 cycles, and `tx_hold` falls in the cycle it reaches zero.
- R4: An accepted pause frame with quanta 0x0000 (XON) drives `tx_hold` and `pause_remaining` to 0 in the next cycle. It does this both during a hold and during a deferred pause.
- R5: A frame counts as a pause only when `rx_dst_addr` equals 48'h0180C2000001, with the first octet on the wire in bits [47:40]. Any other address has no effect.
- R6: While `cfg_pause_ignore` is 1, received pause frames have no effect. This covers both XOFF and XON, and a hold already running continues.
- R7: An XOFF accepted during a hold reloads `pause_remaining` with the new quanta and restarts the 64-cycle slot. It does not add to the time left.
- R8: A frame counts as a pause only when `rx_ethertype` is 16'h8808 and `rx_opcode` is 16'h0001. Any other value has no effect.
- R9: With `srst`=1 sampled, `tx_hold` and `pause_remaining` are 0 in the next cycle.
- R10: While a pause is deferred, `pause_remaining` shows the pending quanta and does not count down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| srst | input | 1 | Synchronous reset, active high |
| rx_pause_vld | input | 1 | One-cycle strobe: the decoded fields below are valid |
| rx_dst_addr | input | 48 | Destination address, first octet in [47:40] |
| rx_ethertype | input | 16 | EtherType field |
| rx_opcode | input | 16 | MAC control opcode |
| rx_quanta | input | 16 | Requested pause quanta |
| tx_busy | input | 1 | Transmitter is sending a frame |
| tx_eof | input | 1 | Last byte of the current frame |
| cfg_pause_ignore | input | 1 | 1: ignore received pause frames |
| tx_hold | output | 1 | 1: the transmitter must not start a frame |
| pause_remaining | output | 16 | Quanta left in the current or pending pause |

## Verification
The assertions assume a few things about the inputs:
- The strobe is a single-cycle pulse.
- `tx_eof` is only raised while `tx_busy` is high.
- The fields are stable while the strobe is high.

The bench drives the strobe for exactly one clock and changes all fields on the falling edge. It raises `tx_eof` for one cycle only at the end of a frame it has opened with `tx_busy`. It never overlaps a pause strobe with the end of a frame, so each expected hold length is a plain product of quanta and 64.

// File: rtl/pause_gate_pkg.sv
package pause_gate_pkg;

    typedef enum logic [1:0] {
        GATE_IDLE  = 2'd0,
        GATE_DEFER = 2'd1,
        GATE_HOLD  = 2'd2
    } gate_state_e;

    localparam logic [47:0] CTRL_MCAST_DA = 48'h0180C2000001;
    localparam logic [15:0] CTRL_ETYPE    = 16'h8808;
    localparam logic [15:0] PAUSE_OPCODE  = 16'h0001;

endpackage

// File: rtl/pause_frame_classify.sv
module pause_frame_classify
    import pause_gate_pkg::*;
#(
    parameter int QW       = 16,
    parameter int ADDR_OCT = 6
) (
    input  logic                  clk,
    input  logic                  srst,
    input  logic                  strobe,
    input  logic [ADDR_OCT*8-1:0] dst_addr,
    input  logic [15:0]           ethertype,
    input  logic [15:0]           opcode,
    input  logic [QW-1:0]         quanta,
    input  logic                  ignore,
    output logic                  is_xoff,
    output logic                  is_xon
);
    localparam logic [ADDR_OCT*8-1:0] MATCH_DA = CTRL_MCAST_DA[ADDR_OCT*8-1:0];

    logic [ADDR_OCT-1:0] octet_ok;
    logic                accept;

    // per-octet address compare
    for (genvar g = 0; g < ADDR_OCT; g++) begin : g_octet
        assign octet_ok[g] = (dst_addr[g*8 +: 8] == MATCH_DA[g*8 +: 8]);
    end

    always_comb begin
        accept = strobe && !ignore && (&octet_ok)
                 && (ethertype == CTRL_ETYPE) && (opcode == PAUSE_OPCODE);
        is_xon  = accept && (quanta == '0);
        is_xoff = accept && (quanta != '0);
    end

    AST_CLASS_EXCLUSIVE: assert property (@(posedge clk) disable iff (srst)
        !(is_xon && is_xoff));                                   // R4
    AST_IGNORE_SILENT: assert property (@(posedge clk) disable iff (srst)
        ignore |-> !(is_xon || is_xoff));                        // R6

endmodule

// File: rtl/pause_slot_timer.sv
module pause_slot_timer #(
    parameter int QW        = 16,
    parameter int SLOT_CLKS = 64
) (
    input  logic          clk,
    input  logic          srst,
    input  logic          load,
    input  logic [QW-1:0] load_val,
    input  logic          clear,
    input  logic          run,
    output logic [QW-1:0] count,
    output logic          expire
);
    localparam int SW = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;
    localparam logic [SW-1:0] SLOT_LAST = SW'(SLOT_CLKS - 1);

    logic [SW-1:0] slot;
    logic          slot_end;

    assign slot_end = (slot == SLOT_LAST);
    assign expire   = run && slot_end && (count == QW'(1));

    always_ff @(posedge clk) begin
        if (srst || clear) begin
            count <= '0;
            slot  <= '0;
        end else if (load) begin
            count <= load_val;
            slot  <= '0;
        end else if (run) begin
            if (slot_end) begin
                slot <= '0;
                if (count != '0)
                    count <= count - QW'(1);
            end else begin
                slot <= slot + SW'(1);
            end
        end else begin
            slot <= '0;
        end
    end

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (srst)
        (run && !load && !clear) |=> (count == $past(count)) || (count == $past(count) - QW'(1))); // R3
    AST_RELOAD_EXACT: assert property (@(posedge clk) disable iff (srst)
        (load && !clear) |=> (count == $past(load_val)));        // R7
    AST_FROZEN_IDLE: assert property (@(posedge clk) disable iff (srst)
        (!run && !load && !clear) |=> $stable(count));           // R10

endmodule

// File: rtl/pause_gate_fsm.sv
module pause_gate_fsm
    import pause_gate_pkg::*;
(
    input  logic clk,
    input  logic srst,
    input  logic is_xoff,
    input  logic is_xon,
    input  logic frame_active,
    input  logic expire,
    output logic tx_hold,
    output logic tmr_load,
    output logic tmr_clear,
    output logic tmr_run
);
    gate_state_e state, state_nx;

    // state register
    always_ff @(posedge clk) begin
        if (srst) state <= GATE_IDLE;
        else      state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            GATE_IDLE: begin
                if (is_xoff)
                    state_nx = frame_active ? GATE_DEFER : GATE_HOLD;
            end
            GATE_DEFER: begin
                if (is_xon)             state_nx = GATE_IDLE;
                else if (!frame_active) state_nx = GATE_HOLD;
            end
            GATE_HOLD: begin
                if (is_xon)       state_nx = GATE_IDLE;
                else if (is_xoff) state_nx = GATE_HOLD;
                else if (expire)  state_nx = GATE_IDLE;
            end
            default: state_nx = GATE_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        tx_hold   = 1'b0;
        tmr_load  = is_xoff;
        tmr_clear = is_xon;
        tmr_run   = 1'b0;
        unique case (state)
            GATE_IDLE:  ;
            GATE_DEFER: ;
            GATE_HOLD: begin
                tx_hold = 1'b1;
                tmr_run = !is_xoff && !is_xon;
            end
            default: ;
        endcase
    end

    AST_DEFER_NO_HOLD: assert property (@(posedge clk) disable iff (srst)
        (state == GATE_DEFER && frame_active && !is_xon) |=> !tx_hold);   // R2
    AST_XON_RELEASES: assert property (@(posedge clk) disable iff (srst)
        is_xon |=> !tx_hold);                                             // R4
    AST_IDLE_NEEDS_XOFF: assert property (@(posedge clk) disable iff (srst)
        (state == GATE_IDLE && !is_xoff) |=> !tx_hold);                   // R1

endmodule

// File: rtl/pause_tx_gate.sv
module pause_tx_gate #(
    parameter int QW        = 16,
    parameter int SLOT_CLKS = 64,
    parameter int ADDR_OCT  = 6
) (
    input  logic                  clk,
    input  logic                  srst,
    input  logic                  rx_pause_vld,
    input  logic [ADDR_OCT*8-1:0] rx_dst_addr,
    input  logic [15:0]           rx_ethertype,
    input  logic [15:0]           rx_opcode,
    input  logic [QW-1:0]         rx_quanta,
    input  logic                  tx_busy,
    input  logic                  tx_eof,
    input  logic                  cfg_pause_ignore,
    output logic                  tx_hold,
    output logic [QW-1:0]         pause_remaining
);
    logic is_xoff, is_xon, frame_active, expire;
    logic tmr_load, tmr_clear, tmr_run;

    assign frame_active = tx_busy && !tx_eof;

    pause_frame_classify #(.QW(QW), .ADDR_OCT(ADDR_OCT)) u_classify (
        .clk(clk), .srst(srst), .strobe(rx_pause_vld), .dst_addr(rx_dst_addr),
        .ethertype(rx_ethertype), .opcode(rx_opcode), .quanta(rx_quanta),
        .ignore(cfg_pause_ignore), .is_xoff(is_xoff), .is_xon(is_xon)
    );

    pause_gate_fsm u_fsm (
        .clk(clk), .srst(srst), .is_xoff(is_xoff), .is_xon(is_xon),
        .frame_active(frame_active), .expire(expire), .tx_hold(tx_hold),
        .tmr_load(tmr_load), .tmr_clear(tmr_clear), .tmr_run(tmr_run)
    );

    pause_slot_timer #(.QW(QW), .SLOT_CLKS(SLOT_CLKS)) u_timer (
        .clk(clk), .srst(srst), .load(tmr_load), .load_val(rx_quanta),
        .clear(tmr_clear), .run(tmr_run), .count(pause_remaining), .expire(expire)
    );

    AST_HOLD_NONZERO: assert property (@(posedge clk) disable iff (srst)
        tx_hold |-> (pause_remaining != '0));                    // R3
    AST_RESET_CLEARS: assert property (@(posedge clk)
        srst |=> (!tx_hold && pause_remaining == '0));           // R9

endmodule

// File: tb/pause_tx_gate_tb.sv
module pause_tx_gate_tb;
    localparam logic [47:0] DA_OK = 48'h0180C2000001;

    logic        clk = 1'b0;
    logic        srst = 1'b1;
    logic        rx_pause_vld = 1'b0;
    logic [47:0] rx_dst_addr = '0;
    logic [15:0] rx_ethertype = '0;
    logic [15:0] rx_opcode = '0;
    logic [15:0] rx_quanta = '0;
    logic        tx_busy = 1'b0;
    logic        tx_eof = 1'b0;
    logic        cfg_pause_ignore = 1'b0;
    logic        tx_hold;
    logic [15:0] pause_remaining;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pause_tx_gate u_dut (
        .clk(clk), .srst(srst), .rx_pause_vld(rx_pause_vld), .rx_dst_addr(rx_dst_addr),
        .rx_ethertype(rx_ethertype), .rx_opcode(rx_opcode), .rx_quanta(rx_quanta),
        .tx_busy(tx_busy), .tx_eof(tx_eof), .cfg_pause_ignore(cfg_pause_ignore),
        .tx_hold(tx_hold), .pause_remaining(pause_remaining)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // call at a falling edge; returns at the falling edge after the strobe was sampled
    task automatic send(input logic [47:0] da, input logic [15:0] et,
                        input logic [15:0] op, input logic [15:0] q);
        rx_dst_addr = da; rx_ethertype = et; rx_opcode = op; rx_quanta = q;
        rx_pause_vld = 1'b1;
        @(negedge clk);
        rx_pause_vld = 1'b0;
    endtask

    task automatic measure(output int n);
        n = 0;
        while (tx_hold && n < 70000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        idle(3);
        srst = 1'b0;
        @(negedge clk);
        check(!tx_hold && pause_remaining == 0, "R9 reset state", int'(pause_remaining), 0);

        // R1: sweep quanta 1..8 and a larger value
        for (int q = 1; q <= 8; q++) begin
            send(DA_OK, 16'h8808, 16'h0001, 16'(q));
            measure(n);
            check(n == q * 64, "R1 hold length", n, q * 64);
            idle(2);
        end
        send(DA_OK, 16'h8808, 16'h0001, 16'h0040);
        measure(n);
        check(n == 64 * 64, "R1 hold length q=64", n, 4096);
        idle(2);

        // R3: one decrement per slot
        send(DA_OK, 16'h8808, 16'h0001, 16'd3);
        check(pause_remaining == 3, "R3 start count", int'(pause_remaining), 3);
        idle(63);
        check(pause_remaining == 3, "R3 before slot end", int'(pause_remaining), 3);
        idle(1);
        check(pause_remaining == 2, "R3 after slot", int'(pause_remaining), 2);
        measure(n);
        check(n == 128 && pause_remaining == 0, "R3 release at zero", n, 128);
        idle(2);

        // R2 / R10: deferral during a frame
        tx_busy = 1'b1;
        idle(2);
        send(DA_OK, 16'h8808, 16'h0001, 16'd2);
        idle(10);
        check(!tx_hold, "R2 no hold mid-frame", int'(tx_hold), 0);
        check(pause_remaining == 2, "R10 pending quanta frozen", int'(pause_remaining), 2);
        tx_eof = 1'b1;
        @(negedge clk);
        tx_eof = 1'b0; tx_busy = 1'b0;
        check(tx_hold, "R2 hold after eof", int'(tx_hold), 1);
        measure(n);
        check(n == 128, "R2 full hold after frame", n, 128);
        idle(2);

        // R4: XON during hold
        send(DA_OK, 16'h8808, 16'h0001, 16'd10);
        idle(20);
        send(DA_OK, 16'h8808, 16'h0001, 16'h0000);
        check(!tx_hold && pause_remaining == 0, "R4 xon release", int'(pause_remaining), 0);
        // R4: XON cancels deferred pause
        tx_busy = 1'b1;
        send(DA_OK, 16'h8808, 16'h0001, 16'd4);
        send(DA_OK, 16'h8808, 16'h0001, 16'h0000);
        tx_busy = 1'b0;
        idle(5);
        check(!tx_hold && pause_remaining == 0, "R4 xon cancels deferral", int'(tx_hold), 0);

        // R7: reload, not add
        send(DA_OK, 16'h8808, 16'h0001, 16'd5);
        idle(100);
        send(DA_OK, 16'h8808, 16'h0001, 16'd2);
        check(pause_remaining == 2, "R7 reload value", int'(pause_remaining), 2);
        measure(n);
        check(n == 128, "R7 reload length", n, 128);
        idle(2);

        // R5: each octet wrong, plus broadcast
        for (int b = 0; b < 6; b++) begin
            logic [47:0] da;
            da = DA_OK ^ (48'h01 << (b * 8));
            send(da, 16'h8808, 16'h0001, 16'd3);
            check(!tx_hold && pause_remaining == 0, "R5 wrong address", int'(pause_remaining), 0);
        end
        send(48'hFFFFFFFFFFFF, 16'h8808, 16'h0001, 16'd3);
        check(!tx_hold && pause_remaining == 0, "R5 broadcast", int'(pause_remaining), 0);

        // R8: wrong EtherType / opcodes
        send(DA_OK, 16'h0800, 16'h0001, 16'd3);
        check(!tx_hold && pause_remaining == 0, "R8 wrong ethertype", int'(pause_remaining), 0);
        send(DA_OK, 16'h8808, 16'h0000, 16'd3);
        check(!tx_hold && pause_remaining == 0, "R8 opcode 0", int'(pause_remaining), 0);
        send(DA_OK, 16'h8808, 16'h0002, 16'd3);
        check(!tx_hold && pause_remaining == 0, "R8 opcode 2", int'(pause_remaining), 0);
        send(DA_OK, 16'h8808, 16'h0101, 16'd3);
        check(!tx_hold && pause_remaining == 0, "R8 opcode 0x101", int'(pause_remaining), 0);

        // R6: ignore bit
        cfg_pause_ignore = 1'b1;
        send(DA_OK, 16'h8808, 16'h0001, 16'd3);
        check(!tx_hold && pause_remaining == 0, "R6 xoff ignored", int'(pause_remaining), 0);
        cfg_pause_ignore = 1'b0;
        send(DA_OK, 16'h8808, 16'h0001, 16'd4);
        cfg_pause_ignore = 1'b1;
        send(DA_OK, 16'h8808, 16'h0001, 16'h0000);
        check(tx_hold && pause_remaining == 4, "R6 xon ignored", int'(pause_remaining), 4);
        cfg_pause_ignore = 1'b0;
        send(DA_OK, 16'h8808, 16'h0001, 16'h0000);
        check(!tx_hold, "R4 xon after ignore cleared", int'(tx_hold), 0);

        // R9: reset mid-pause
        send(DA_OK, 16'h8808, 16'h0001, 16'd6);
        idle(10);
        srst = 1'b1;
        @(negedge clk);
        srst = 1'b0;
        check(!tx_hold && pause_remaining == 0, "R9 reset mid-pause", int'(pause_remaining), 0);
        idle(3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule